// File: doc/BRIEF.md
# Adaptive Rectifier Gate Timing Channel

This block is one channel of a synchronous-rectifier gate controller, written as clocked digital logic. It reads four synchronized flags. The first is a conduction-window permission from an external interlock. The other three come from comparators: a turn-on current detect, a turn-off threshold crossing, and a zero-referenced current reversal. From these it drives a single gate-enable output. The analog comparators, current sources and gate driver lie outside the block.

The turn-on request must persist for a debounce interval before the gate is enabled. Every conduction interval is timed in clock cycles. When the gate turns off, the measured length is kept, and half of it becomes the blanking limit for the next interval. While the blanking limit has not been passed, the turn-off threshold flag is masked and only the reversal flag can end conduction. Once the limit is passed, the threshold flag ends conduction after one registered stage.

Each permission window allows at most one conduction. The channel reports every turn-off with a pulse. It also flags a window that closed without any turn-on.

Top module: `sr_gate_channel`

## Requirements
- R1: Hunting for turn-on starts on the edge after `arm_i` is first sampled high. `gate_en_o` rises at the edge on which `on_det_i` has been sampled high on `DB_CYC` consecutive edges (default 25, i.e. 250 ns at 100 MHz) while hunting. A single low sample restarts the count from zero.
- R2: Let E be the number of cycles `gate_en_o` has been high before an edge, and L the blanking limit. While E is less than or equal to L, `off_thr_i` has no effect on `gate_en_o`.
- R3: At every turn-off, E is stored (the on-time). From the following cycle, L equals that stored value shifted right by one bit. After reset, L is zero, so the threshold flag is honoured from the first cycle of conduction.
- R4: `rev_i` sampled high while the gate is on clears `gate_en_o` on that same edge, whatever the values of E and L.
- R5: `off_thr_i` sampled high while the gate is on and E is greater than L clears `gate_en_o` on that same edge. This is a single 10 ns register stage.
- R6: After a turn-off, `gate_en_o` stays low for as long as `arm_i` stays high, even if `on_det_i` stays asserted. A new conduction needs `arm_i` to be sampled low and then high again.
- R7: `on_done_o` is a one-cycle pulse. It is high in exactly the cycle in which `gate_en_o` first reads low after conduction.
- R8: The on-time count stops at 2^`CNT_W`-1 and does not wrap. A saturated measurement gives L = 2^(`CNT_W`-1)-1.
- R9: If `arm_i` is sampled low while the channel is still hunting, `missed_on_o` is high for exactly the following cycle.
- R10: `arm_i` sampled low while the gate is on clears `gate_en_o` on that edge. This counts as a turn-off: it raises `on_done_o` and stores the on-time.
- R11: A synchronous active-high reset clears all three outputs and sets L to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (100 MHz nominal) |
| rst_i | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | Interlock permission; high marks a conduction window |
| on_det_i | input | 1 | Turn-on current detect flag |
| off_thr_i | input | 1 | Turn-off threshold crossed flag |
| rev_i | input | 1 | Current reversal (zero-referenced) flag |
| gate_en_o | output | 1 | Gate enable |
| on_done_o | output | 1 | One-cycle pulse at each turn-off |
| missed_on_o | output | 1 | One-cycle pulse when a window ends with no turn-on |

## Verification
The assertions check, on every cycle, these properties:
- Reversal, threshold-after-blanking and loss of permission each drop the gate one edge later.
- The threshold flag never drops the gate inside the blanking interval.
- A gate rise is always preceded by a full run of detect samples.
- No second rise happens inside a window.
- The done pulse coincides with each gate fall.
- Each new limit is half of the interval that has just ended.

Only the bench scenarios can show some other behaviours, because they need whole sequences of windows:
- a glitch in the detect flag restarts the debounce;
- an interval's measured length moves the next interval's blanking point;
- the count saturates on a long conduction;
- a window with no turn-on is flagged.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

    // Channel sequencing states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,   // no permission
        ST_HUNT    = 2'd1,   // permitted, debouncing turn-on detect
        ST_CONDUCT = 2'd2,   // gate enabled
        ST_SPENT   = 2'd3    // conducted once in this window
    } chan_state_e;

    // Synchronized input flags, bundled
    typedef struct packed {
        logic arm;
        logic on_det;
        logic off_thr;
        logic rev;
    } chan_flags_t;

    // Registered outputs, bundled
    typedef struct packed {
        logic gate;
        logic done;
        logic miss;
    } chan_outs_t;

    localparam int unsigned DEF_DB_CYC = 25;
    localparam int unsigned DEF_CNT_W  = 16;

    // True when any flag demands an end to conduction
    function automatic logic off_request(input chan_flags_t f, input logic honor);
        return (!f.arm) || f.rev || (f.off_thr && honor);
    endfunction

endpackage

// File: rtl/sr_on_debounce.sv
module sr_on_debounce #(
    parameter int unsigned DB_CYC = 25
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    input  logic det_i,
    output logic fire_o
);
    localparam int unsigned DB_W = $clog2(DB_CYC + 1);
    localparam logic [DB_W-1:0] LAST = DB_W'(DB_CYC - 1);
    localparam logic [DB_W-1:0] STEP = DB_W'(1);

    logic [DB_W-1:0] run_q;

    // Fires on the sample that completes the consecutive run
    assign fire_o = enable_i && det_i && (run_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !enable_i || !det_i || fire_o) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + STEP;
        end
    end
endmodule

// File: rtl/sr_ontime_meter.sv
module sr_ontime_meter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] elapsed_o,
    output logic [CNT_W-1:0] limit_o,
    output logic             honor_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] elapsed_q;
    logic [CNT_W-1:0] measured_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            elapsed_q  <= '0;
            measured_q <= '0;
        end else begin
            if (start_i) begin
                elapsed_q <= ONE;
            end else if (run_i && !stop_i && (elapsed_q != CNT_MAX)) begin
                elapsed_q <= elapsed_q + ONE;
            end
            if (stop_i) begin
                measured_q <= elapsed_q;
            end
        end
    end

    assign elapsed_o = elapsed_q;
    assign limit_o   = measured_q >> 1;
    assign honor_o   = elapsed_q > limit_o;
endmodule

// File: rtl/sr_gate_fsm.sv
module sr_gate_fsm
    import sr_gate_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  chan_flags_t flags_i,
    input  logic        fire_i,
    input  logic        honor_i,
    output logic        hunt_o,
    output logic        start_o,
    output logic        run_o,
    output logic        stop_o,
    output chan_outs_t  outs_o
);
    chan_state_e state_q, state_d;
    chan_outs_t  outs_q, outs_d;

    assign hunt_o  = (state_q == ST_HUNT) && flags_i.arm;
    assign run_o   = (state_q == ST_CONDUCT);
    assign stop_o  = run_o && off_request(flags_i, honor_i);
    assign start_o = (state_q == ST_HUNT) && flags_i.arm && fire_i;

    always_comb begin
        state_d = state_q;
        outs_d  = '{gate: outs_q.gate, done: 1'b0, miss: 1'b0};
        unique case (state_q)
            ST_IDLE: begin
                if (flags_i.arm) state_d = ST_HUNT;
            end
            ST_HUNT: begin
                if (!flags_i.arm) begin
                    state_d     = ST_IDLE;
                    outs_d.miss = 1'b1;
                end else if (fire_i) begin
                    state_d     = ST_CONDUCT;
                    outs_d.gate = 1'b1;
                end
            end
            ST_CONDUCT: begin
                if (stop_o) begin
                    outs_d.gate = 1'b0;
                    outs_d.done = 1'b1;
                    state_d     = flags_i.arm ? ST_SPENT : ST_IDLE;
                end
            end
            ST_SPENT: begin
                if (!flags_i.arm) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            outs_q  <= '0;
        end else begin
            state_q <= state_d;
            outs_q  <= outs_d;
        end
    end

    assign outs_o = outs_q;
endmodule

// File: rtl/sr_gate_channel.sv
module sr_gate_channel
    import sr_gate_pkg::*;
#(
    parameter int unsigned DB_CYC = DEF_DB_CYC,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    input  logic on_det_i,
    input  logic off_thr_i,
    input  logic rev_i,
    output logic gate_en_o,
    output logic on_done_o,
    output logic missed_on_o
);
    chan_flags_t      flags;
    chan_outs_t       outs;
    logic             hunt_w, fire_w, start_w, run_w, stop_w, honor_w;
    logic [CNT_W-1:0] elapsed_w, limit_w;

    assign flags = '{arm: arm_i, on_det: on_det_i, off_thr: off_thr_i, rev: rev_i};

    sr_on_debounce #(.DB_CYC(DB_CYC)) u_deb (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .enable_i (hunt_w),
        .det_i    (on_det_i),
        .fire_o   (fire_w)
    );

    sr_ontime_meter #(.CNT_W(CNT_W)) u_meter (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .start_i   (start_w),
        .run_i     (run_w),
        .stop_i    (stop_w),
        .elapsed_o (elapsed_w),
        .limit_o   (limit_w),
        .honor_o   (honor_w)
    );

    sr_gate_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .flags_i (flags),
        .fire_i  (fire_w),
        .honor_i (honor_w),
        .hunt_o  (hunt_w),
        .start_o (start_w),
        .run_o   (run_w),
        .stop_o  (stop_w),
        .outs_o  (outs)
    );

    assign gate_en_o   = outs.gate;
    assign on_done_o   = outs.done;
    assign missed_on_o = outs.miss;
endmodule

// File: rtl/sr_gate_chk.sv
module sr_gate_chk #(
    parameter int unsigned DB_CYC = 25,
    parameter int unsigned CNT_W  = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             arm_i,
    input logic             on_det_i,
    input logic             off_thr_i,
    input logic             rev_i,
    input logic             gate_en_o,
    input logic             on_done_o,
    input logic             missed_on_o,
    input logic [CNT_W-1:0] elapsed,
    input logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    int   hi_run;      // consecutive high samples of the detect flag
    logic fired_q;     // a conduction already happened in this window

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run  <= 0;
            fired_q <= 1'b0;
        end else begin
            hi_run  <= on_det_i ? ((hi_run < int'(DB_CYC)) ? hi_run + 1 : hi_run) : 0;
            if (!arm_i)         fired_q <= 1'b0;
            else if (gate_en_o) fired_q <= 1'b1;
        end
    end

    p_debounce_run_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_en_o) |-> hi_run >= int'(DB_CYC));

    p_blank_mask_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_en_o && arm_i && !rev_i && (elapsed <= limit) |=> gate_en_o);

    p_limit_half_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        on_done_o |-> limit == ($past(elapsed) >> 1));

    p_reverse_off_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_en_o && rev_i |=> !gate_en_o);

    p_thr_off_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_en_o && off_thr_i && (elapsed > limit) |=> !gate_en_o);

    p_single_fire_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_en_o) |-> !fired_q);

    p_done_on_fall_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(gate_en_o) |-> on_done_o);

    p_done_only_fall_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        on_done_o |-> !gate_en_o && $past(gate_en_o));

    p_count_sat_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_en_o && arm_i && !rev_i && !off_thr_i && (elapsed == CNT_MAX) |=> elapsed == CNT_MAX);

    p_miss_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        missed_on_o |-> !gate_en_o && !on_done_o);

    p_unarmed_off_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_en_o && !arm_i |=> !gate_en_o && on_done_o);
endmodule

bind sr_gate_channel sr_gate_chk #(.DB_CYC(DB_CYC), .CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .arm_i       (arm_i),
    .on_det_i    (on_det_i),
    .off_thr_i   (off_thr_i),
    .rev_i       (rev_i),
    .gate_en_o   (gate_en_o),
    .on_done_o   (on_done_o),
    .missed_on_o (missed_on_o),
    .elapsed     (elapsed_w),
    .limit       (limit_w)
);

// File: tb/sr_gate_channel_tb_top.sv
module sr_gate_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DB  = 25;
    localparam int CW  = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0, on_det = 1'b0, off_thr = 1'b0, rev = 1'b0;
    logic gate_en, on_done, missed_on;

    int checks = 0;
    int fails  = 0;
    string tag = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_gate_channel #(.DB_CYC(DB), .CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_i(rst), .arm_i(arm), .on_det_i(on_det),
        .off_thr_i(off_thr), .rev_i(rev),
        .gate_en_o(gate_en), .on_done_o(on_done), .missed_on_o(missed_on)
    );

    // Behavioural reference: phase 0 idle, 1 hunting, 2 conducting, 3 spent
    int phase = 0, hits = 0, ontime = 0, last_on = 0;
    bit m_gate = 0, m_done = 0, m_miss = 0;

    always @(posedge clk) begin
        if (rst) begin
            phase = 0; hits = 0; ontime = 0; last_on = 0;
            m_gate = 0; m_done = 0; m_miss = 0;
        end else begin
            m_done = 0; m_miss = 0;
            if (phase == 0) begin
                if (arm) begin phase = 1; hits = 0; end
            end else if (phase == 1) begin
                if (!arm) begin phase = 0; m_miss = 1; end
                else if (on_det) begin
                    hits++;
                    if (hits >= DB) begin phase = 2; m_gate = 1; ontime = 1; end
                end else hits = 0;
            end else if (phase == 2) begin
                if (rev || !arm || (off_thr && ontime > last_on / 2)) begin
                    m_gate = 0; m_done = 1; last_on = ontime;
                    phase = arm ? 3 : 0;
                end else if (ontime < MAXC) ontime++;
            end else begin
                if (!arm) phase = 0;
            end
        end
    end

    // Compare on every falling edge once reset is released
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if ({gate_en, on_done, missed_on} !== {m_gate, m_done, m_miss}) begin
                fails++;
                $display("FAIL %s t=%0t gate/done/miss actual=%b%b%b expected=%b%b%b",
                         tag, $time, gate_en, on_done, missed_on, m_gate, m_done, m_miss);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic close_window();
        arm = 0; on_det = 0; off_thr = 0; rev = 0;
        tick(3);
    endtask

    task automatic begin_conduct();
        arm = 1; on_det = 1;
        tick(DB + 2);
        on_det = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        tick(CLK_PERIOD - 7);
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
    end

    initial begin
        tick(3);
        // R11: reset state
        checks++;
        if ({gate_en, on_done, missed_on} !== 3'b000) begin
            fails++;
            $display("FAIL R11 reset outputs actual=%b%b%b expected=000", gate_en, on_done, missed_on);
        end
        rst = 0;
        tick(2);

        // R1 debounce with a glitch; R3/R5 limit zero after reset; R6 no retrigger
        tag = "R1"; arm = 1; on_det = 1; tick(10);
        on_det = 0; tick(1);
        on_det = 1; tick(DB + 4);
        tag = "R5"; off_thr = 1; tick(1); off_thr = 0;
        tag = "R6"; tick(15);
        close_window();

        // R2 threshold held through blanking, R3 new limit
        tag = "R2"; begin_conduct(); off_thr = 1; tick(10); off_thr = 0;
        close_window();
        tag = "R3"; begin_conduct(); tick(40); off_thr = 1; tick(2);
        close_window();

        // R4 reversal inside blanking interval
        tag = "R4"; begin_conduct(); off_thr = 1; tick(4); rev = 1; tick(2);
        close_window();

        // R9 window without turn-on
        tag = "R9"; arm = 1; on_det = 1; tick(10); on_det = 0; tick(5);
        close_window();

        // R10 permission lost during conduction, R7 done pulse
        tag = "R10"; begin_conduct(); tick(8);
        close_window();
        tag = "R7"; begin_conduct(); rev = 1; tick(3);
        close_window();

        // R8 saturation and the resulting limit
        tag = "R8"; begin_conduct(); tick(MAXC + 50); off_thr = 1; tick(2);
        close_window();
        begin_conduct(); off_thr = 1; tick(MAXC);
        close_window();

        tick(5);
        summary();
    end
endmodule